// File: doc/BRIEF.md
# SDRAM Clock-Enable Suspend and Power-Down Control

This block sits at the front of a mobile SDR SDRAM device model and turns the sampled clock-enable pin into an internal qualifier for the rest of the model. On every rising clock edge it samples the clock-enable input, a per-bank idle vector and the command pins. From these it decides whether the internal clock runs in the next cycle. When the internal clock stops, the block separates two cases. If any bank still holds an open row, it is a clock suspend. If every bank is idle when clock-enable is seen low, it is a power-down.

The outputs are a clock-active qualifier for the downstream model and a freeze strobe that holds output data and the burst address counter. There is also a power-down status flag, and a command-accept strobe that tells the command decoder a real command is present in the current cycle. Both entry and exit happen one cycle after the clock-enable sample that causes them. While the internal clock is stopped, every input other than clock-enable is ignored.

Top module: `sdr_cke_ctrl`

## Requirements
- R1: A command presented in the cycle in which clock-enable is first sampled low is still accepted: cmd_accept is high in that cycle when it holds a real command.
- R2: When clock-enable is sampled low while the internal clock runs, clk_active is low from the next cycle onward.
- R3: freeze is high in every cycle in which clk_active is low, and low otherwise.
- R4: If every bit of bank_idle is 1 (1 = bank idle) when clock-enable is sampled low, pd_active is high from the next cycle.
- R5: If any bit of bank_idle is 0 when clock-enable is sampled low, only suspend is entered, and pd_active stays low for the whole stop.
- R6: While the internal clock is stopped, command pins and bank_idle have no effect: cmd_accept stays low, and a suspend does not turn into power-down.
- R7: Exit is synchronous. When clock-enable is sampled high while stopped, clk_active is high in the next cycle, and commands are accepted in that cycle.
- R8: A synchronous active-low reset puts the block in the running state: clk_active is high and pd_active is low after the reset edge, even during power-down.
- R9: cmd_accept is high only when the clock is active, cs_n is 0, and ras_n, cas_n and we_n are not all 1. A deselect (cs_n = 1) or a NOP (ras_n = cas_n = we_n = 1) is never accepted.
- R10: pd_active stays high from power-down entry through the cycle in which clock-enable is sampled high again, and falls in the cycle after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| bank_idle | input | NUM_BANKS | Per-bank idle status, 1 = idle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| clk_active | output | 1 | Internal clock runs in this cycle |
| freeze | output | 1 | Hold output data and burst address |
| pd_active | output | 1 | Device is in power-down |
| cmd_accept | output | 1 | A real command is decoded this cycle |

## Verification
The bench drops clock-enable together with a read, to show that the command in the entry cycle is kept. A design that gated one cycle early would lose that read. A suspend is started with one bank open, and then all banks are reported idle while the clock is stopped. A design that kept watching bank_idle would move into power-down. Exits are checked in the cycle in which clock-enable is sampled high, where an early exit would show too soon. A reset asserted in the middle of a power-down must return the block to the running state.

// File: rtl/sdr_cke_pkg.sv
package sdr_cke_pkg;

   typedef enum logic [1:0] {
      CK_RUN  = 2'd0,
      CK_SUSP = 2'd1,
      CK_PDN  = 2'd2
   } ck_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   // Strobe combination that carries no operation.
   function automatic logic cmd_is_nop(input cmd_pins_t c);
      return c.ras_n & c.cas_n & c.we_n;
   endfunction

   // Where a stop lands, based on the bank picture at the stopping edge.
   function automatic ck_state_e stop_target(input logic all_idle);
      return all_idle ? CK_PDN : CK_SUSP;
   endfunction

endpackage

// File: rtl/sdr_cke_idle_scan.sv
module sdr_cke_idle_scan #(
   parameter int NUM_BANKS = 4
) (
   input  logic [NUM_BANKS-1:0] bank_idle,
   output logic                 all_idle
);
   generate
      if (NUM_BANKS == 1) begin : g_single
         assign all_idle = bank_idle[0];
      end else begin : g_multi
         assign all_idle = &bank_idle;
      end
   endgenerate
endmodule

// File: rtl/sdr_cke_fsm.sv
module sdr_cke_fsm
   import sdr_cke_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cke,
   input  logic      all_idle,
   output ck_state_e state
);
   ck_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         CK_RUN:          if (!cke) nxt = stop_target(all_idle);
         CK_SUSP, CK_PDN: if (cke)  nxt = CK_RUN;
         default:         nxt = CK_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= CK_RUN;
      else        state <= nxt;
   end
endmodule

// File: rtl/sdr_cke_cmd_gate.sv
module sdr_cke_cmd_gate
   import sdr_cke_pkg::*;
(
   input  ck_state_e state,
   input  cmd_pins_t cmd,
   output logic      clk_active,
   output logic      freeze,
   output logic      pd_active,
   output logic      cmd_accept
);
   assign clk_active = (state == CK_RUN);
   assign freeze     = !clk_active;
   assign pd_active  = (state == CK_PDN);
   assign cmd_accept = clk_active & !cmd.cs_n & !cmd_is_nop(cmd);
endmodule

// File: rtl/sdr_cke_ctrl.sv
module sdr_cke_ctrl
   import sdr_cke_pkg::*;
#(
   parameter int NUM_BANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic [NUM_BANKS-1:0] bank_idle,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   output logic                 clk_active,
   output logic                 freeze,
   output logic                 pd_active,
   output logic                 cmd_accept
);
   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 16) begin : g_bad_banks
         $error("sdr_cke_ctrl: NUM_BANKS must be 1..16");
      end
   endgenerate

   logic      all_idle;
   ck_state_e state;
   cmd_pins_t cmd;

   assign cmd = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

   sdr_cke_idle_scan #(.NUM_BANKS(NUM_BANKS)) u_scan (
      .bank_idle (bank_idle),
      .all_idle  (all_idle)
   );

   sdr_cke_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .all_idle (all_idle),
      .state    (state)
   );

   sdr_cke_cmd_gate u_gate (
      .state      (state),
      .cmd        (cmd),
      .clk_active (clk_active),
      .freeze     (freeze),
      .pd_active  (pd_active),
      .cmd_accept (cmd_accept)
   );
endmodule

// File: rtl/sdr_cke_ctrl_chk.sv
module sdr_cke_ctrl_chk #(
   parameter int NUM_BANKS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cke,
   input logic [NUM_BANKS-1:0] bank_idle,
   input logic                 cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n,
   input logic                 clk_active,
   input logic                 freeze,
   input logic                 pd_active,
   input logic                 cmd_accept
);
   AST_STOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_active && !cke) |=> !clk_active); // R2
   AST_FREEZE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_active && !cke) |=> freeze); // R3
   AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_active && !cke && (&bank_idle)) |=> pd_active); // R4
   AST_SUSP_NO_PD: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_active && !cke && !(&bank_idle)) |=> !pd_active); // R5
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_active && !cke) |=> (!clk_active && $stable(pd_active))); // R6
   AST_NO_ACCEPT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_active |-> !cmd_accept); // R6
   AST_EXIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_active && cke) |=> clk_active); // R7
   AST_RESET_RUN: assert property (@(posedge clk)
      !rst_n |=> (clk_active && !pd_active)); // R8
   AST_NO_NOP_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || (ras_n && cas_n && we_n)) |-> !cmd_accept); // R9
endmodule

bind sdr_cke_ctrl sdr_cke_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/sim_sdr_cke_ctrl.sv
module sim_sdr_cke_ctrl;
   localparam int  NB     = 4;
   localparam time CLK_PD = 10;
   localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                          C_PRE = 4'b0010, C_NOP = 4'b0111, C_DES = 4'b1000;
   localparam logic [NB-1:0] ALL_IDLE = '1, ONE_OPEN = 4'b1110;

   logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
   logic [NB-1:0] bank_idle = '1;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic clk_active, freeze, pd_active, cmd_accept;

   int n_cmp = 0, n_bad = 0, mst = 0;
   bit done = 0;
   logic [3:0] q_exp[$];
   string      q_tag[$];

   always #(CLK_PD/2) clk = ~clk;

   sdr_cke_ctrl #(.NUM_BANKS(NB)) u0 (.*);

   // Driver: applies one cycle of stimulus and pushes the expected outputs.
   task automatic step(input logic r, input logic k, input logic [NB-1:0] idl,
                       input logic [3:0] cmd, input bit chk, input string tag);
      logic act;
      @(negedge clk);
      rst_n = !r; cke = k; bank_idle = idl;
      {cs_n, ras_n, cas_n, we_n} = cmd;
      if (chk) begin
         act = (mst == 0);
         q_exp.push_back({act, !act, mst == 2,
                          act && !cmd[3] && !(cmd[2] && cmd[1] && cmd[0])});
         q_tag.push_back(tag);
      end
      if (r) mst = 0;
      else if (mst == 0) begin if (!k) mst = (&idl) ? 2 : 1; end
      else if (k) mst = 0;
   endtask

   // Monitor: compares outputs after they settle, away from the clock edge.
   always @(negedge clk) begin
      #1;
      if (q_exp.size() > 0) begin
         logic [3:0] e, a;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         a = {clk_active, freeze, pd_active, cmd_accept};
         n_cmp++;
         if (a !== e) begin
            n_bad++;
            $display("FAIL %s: {act,frz,pd,acc} actual=%b expected=%b", t, a, e);
         end
      end
   end

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(1, 1, ALL_IDLE, C_NOP, 0, "R8");
      step(1, 1, ALL_IDLE, C_NOP, 1, "R8 reset state");
      step(0, 1, ALL_IDLE, C_ACT, 1, "R9 act accepted");
      step(0, 1, ONE_OPEN, C_NOP, 1, "R9 nop rejected");
      step(0, 1, ONE_OPEN, C_DES, 1, "R9 deselect rejected");
      // Suspend with one bank open; read in the entry cycle is kept.
      step(0, 0, ONE_OPEN, C_RD,  1, "R1 entry-cycle read");
      step(0, 0, ALL_IDLE, C_WR,  1, "R2 R3 R5 suspended");
      step(0, 0, ALL_IDLE, C_ACT, 1, "R6 idle change ignored");
      step(0, 1, ALL_IDLE, C_RD,  1, "R6 exit-sample cycle");
      step(0, 1, ONE_OPEN, C_RD,  1, "R7 resumed read");
      // Power-down with all banks idle.
      step(0, 0, ALL_IDLE, C_PRE, 1, "R1 entry-cycle precharge");
      step(0, 0, ONE_OPEN, C_ACT, 1, "R4 power-down entered");
      step(0, 0, ALL_IDLE, C_WR,  1, "R6 pd ignores command");
      step(0, 1, ALL_IDLE, C_ACT, 1, "R10 pd held at exit sample");
      step(0, 1, ALL_IDLE, C_ACT, 1, "R7 R10 pd exited");
      step(0, 1, ALL_IDLE, C_WR,  1, "R7 write after exit");
      // Single-cycle low pulse into suspend and straight back.
      step(0, 0, 4'b0111, C_RD,  1, "R1 pulse entry");
      step(0, 1, ALL_IDLE, C_RD,  1, "R5 pulse stopped");
      step(0, 1, ALL_IDLE, C_RD,  1, "R7 pulse resumed");
      // Reset during power-down.
      step(0, 0, ALL_IDLE, C_NOP, 1, "R9 nop at pd entry");
      step(0, 0, ALL_IDLE, C_NOP, 1, "R4 pd before reset");
      step(1, 0, ALL_IDLE, C_RD,  1, "R8 reset edge in pd");
      step(0, 1, ALL_IDLE, C_RD,  1, "R8 running after reset");
      @(negedge clk);
      #2;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule